// File: doc/BRIEF.md
# Speculative Retirement Queue with Branch Recovery

This block is a circular queue that holds decoded instructions from issue until retirement in a speculative core that issues in program order. The issue stage writes an instruction into the slot at the tail. The index of that slot is returned at once as the instruction's rename tag, so later consumers refer to the tag and not to an architectural register name. Execution units report results by tag, in any order. Load and store slots also carry a dispatch flag: a load or store result is accepted only after the access has been marked as sent to memory.

Retirement happens only at the head slot, and only once that slot holds its result. A retiring load or arithmetic instruction drives a register-file write port in the same cycle. A retiring branch is checked against its resolved outcome. The next address that was used at issue must equal the resolved target when the condition is zero, and the branch address plus one otherwise. A wrong guess raises the flush signal and presents the correct address in that same cycle. The whole queue is then empty on the following cycle.

Top module: `rob_core`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `commit_valid`, `rf_we` and `flush` are 0.
- R2: An accepted allocation (`alloc_valid` and `alloc_ready`) receives the tag shown on `alloc_tag`. Tags are handed out in order 0, 1, …, DEPTH-1 and then wrap to 0.
- R3: With DEPTH entries held, `alloc_ready` is 0 and an offered allocation is ignored. The tag does not advance.
- R4: Entries retire strictly in allocation order, at most one per cycle. An entry whose result has arrived does not retire while any older entry is still waiting.
- R5: When a slot of class ALU (`alloc_kind`=0) or load (2) retires, `rf_we` is 1 with `rf_waddr` equal to its destination and `rf_wdata` equal to its last captured result. When a branch (1) or store (3) retires, `rf_we` is 0.
- R6: A retiring branch is correctly predicted when either of two conditions holds. If `res_zero` was 1, the stored prediction must equal the captured result value (the target). If `res_zero` was 0, the stored prediction must equal the branch address plus one. A correctly predicted branch retires with `flush` at 0.
- R7: A mispredicted branch raises `flush` in its retirement cycle, with `redirect_pc` set to the correct next address. In that cycle `alloc_ready` is 0. On the next cycle the queue is empty and `alloc_tag` is 0.
- R8: A result for a load or store slot is ignored until a `mem_go_valid` pulse has marked that slot as dispatched. A dispatch and a result for the same slot in the same cycle leave the result ignored.
- R9: A result or dispatch carrying the tag of an unoccupied slot has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue stage offers an instruction |
| alloc_kind | input | 2 | Class: 0 ALU, 1 branch, 2 load, 3 store |
| alloc_pc | input | XLEN | Instruction address |
| alloc_dst | input | AREG_W | Destination register (ALU and load) |
| alloc_pred | input | XLEN | Next address used at issue (branch) |
| alloc_ready | output | 1 | Allocation will be accepted this cycle |
| alloc_tag | output | TAG_W | Tag given to the offered instruction |
| res_valid | input | 1 | Execution result present |
| res_tag | input | TAG_W | Tag of the result |
| res_value | input | XLEN | Result data, or resolved target for a branch |
| res_zero | input | 1 | Branch condition value was zero |
| mem_go_valid | input | 1 | Memory access dispatched |
| mem_go_tag | input | TAG_W | Tag of the dispatched access |
| commit_valid | output | 1 | Head entry retires this cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | AREG_W | Register-file write index |
| rf_wdata | output | XLEN | Register-file write data |
| flush | output | 1 | Misprediction: discard all entries |
| redirect_pc | output | XLEN | Correct next address when flushing |

## Verification
The assertions rely on a few assumptions about the environment. The issue stage honours `alloc_ready`. Result and dispatch tags are always inside the range 0..DEPTH-1. A branch's result carries its resolved target on `res_value`. The stimulus respects these assumptions. Random tags are drawn only from the legal range, and allocations are offered freely: a refused offer must simply leave no trace. Branch results reuse the stored prediction about half of the time, so correct and wrong guesses both occur often. Directed sequences cover filling the queue, retirement after out-of-order completion, early memory results, stale tags, and both kinds of misprediction.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        K_ALU   = 2'd0,
        K_BR    = 2'd1,
        K_LOAD  = 2'd2,
        K_STORE = 2'd3
    } rob_kind_e;

    function automatic logic kind_writes_reg(input logic [1:0] k);
        return (k == K_ALU) || (k == K_LOAD);
    endfunction

    function automatic logic kind_is_mem(input logic [1:0] k);
        return (k == K_LOAD) || (k == K_STORE);
    endfunction
endpackage

// File: rtl/rob_tag_dec.sv
module rob_tag_dec #(
    parameter int DEPTH = 8,
    parameter int TAG_W = $clog2(DEPTH)
) (
    input  logic             en,
    input  logic [TAG_W-1:0] tag,
    output logic [DEPTH-1:0] hit
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_hit
        assign hit[i] = en && (tag == TAG_W'(i));
    end
endmodule

// File: rtl/rob_br_check.sv
module rob_br_check #(
    parameter int XLEN = 16
) (
    input  logic [XLEN-1:0] br_pc,
    input  logic [XLEN-1:0] br_pred,
    input  logic [XLEN-1:0] br_target,
    input  logic            br_zero,
    output logic [XLEN-1:0] true_next,
    output logic            wrong
);
    always_comb begin
        true_next = br_zero ? br_target : (br_pc + XLEN'(1));
        wrong     = (br_pred != true_next);
    end
endmodule

// File: rtl/rob_core.sv
module rob_core #(
    parameter int DEPTH  = 8,
    parameter int XLEN   = 16,
    parameter int AREG_W = 4,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [1:0]        alloc_kind,
    input  logic [XLEN-1:0]   alloc_pc,
    input  logic [AREG_W-1:0] alloc_dst,
    input  logic [XLEN-1:0]   alloc_pred,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [XLEN-1:0]   res_value,
    input  logic              res_zero,
    input  logic              mem_go_valid,
    input  logic [TAG_W-1:0]  mem_go_tag,
    output logic              commit_valid,
    output logic              rf_we,
    output logic [AREG_W-1:0] rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic              flush,
    output logic [XLEN-1:0]   redirect_pc
);
    import rob_pkg::*;

    typedef struct packed {
        logic              used;
        logic              done;
        logic              sent;
        logic [1:0]        kind;
        logic [XLEN-1:0]   pc;
        logic [XLEN-1:0]   pred;
        logic [XLEN-1:0]   val;
        logic              zero;
        logic [AREG_W-1:0] dst;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slots;
        logic [TAG_W-1:0]  head;
        logic [TAG_W-1:0]  tail;
        logic [CNT_W-1:0]  count;
    } rob_state_t;

    function automatic logic [TAG_W-1:0] step_idx(input logic [TAG_W-1:0] idx);
        return (idx == TAG_W'(DEPTH - 1)) ? '0 : idx + TAG_W'(1);
    endfunction

    rob_state_t st_q, st_d;
    slot_t      head_q;
    logic [DEPTH-1:0] res_hit, go_hit;
    logic [XLEN-1:0]  br_next;
    logic             br_wrong;
    logic             full, do_alloc, do_retire;

    rob_tag_dec #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_res_dec (
        .en(res_valid), .tag(res_tag), .hit(res_hit)
    );
    rob_tag_dec #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_go_dec (
        .en(mem_go_valid), .tag(mem_go_tag), .hit(go_hit)
    );

    assign head_q = st_q.slots[st_q.head];

    rob_br_check #(.XLEN(XLEN)) u_br (
        .br_pc(head_q.pc), .br_pred(head_q.pred), .br_target(head_q.val),
        .br_zero(head_q.zero), .true_next(br_next), .wrong(br_wrong)
    );

    always_comb begin
        commit_valid = head_q.used && head_q.done;
        flush        = commit_valid && (head_q.kind == K_BR) && br_wrong;
        redirect_pc  = br_next;
        rf_we        = commit_valid && kind_writes_reg(head_q.kind);
        rf_waddr     = head_q.dst;
        rf_wdata     = head_q.val;
        full         = (st_q.count == CNT_W'(DEPTH));
        alloc_ready  = !full && !flush;
        alloc_tag    = st_q.tail;
        do_alloc     = alloc_valid && alloc_ready;
        do_retire    = commit_valid && !flush;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (res_hit[i] && st_q.slots[i].used &&
                (!kind_is_mem(st_q.slots[i].kind) || st_q.slots[i].sent)) begin
                st_d.slots[i].done = 1'b1;
                st_d.slots[i].val  = res_value;
                st_d.slots[i].zero = res_zero;
            end
            if (go_hit[i] && st_q.slots[i].used && kind_is_mem(st_q.slots[i].kind)) begin
                st_d.slots[i].sent = 1'b1;
            end
        end
        if (do_alloc) begin
            st_d.slots[st_q.tail].used = 1'b1;
            st_d.slots[st_q.tail].done = 1'b0;
            st_d.slots[st_q.tail].sent = 1'b0;
            st_d.slots[st_q.tail].kind = alloc_kind;
            st_d.slots[st_q.tail].pc   = alloc_pc;
            st_d.slots[st_q.tail].pred = alloc_pred;
            st_d.slots[st_q.tail].val  = '0;
            st_d.slots[st_q.tail].zero = 1'b0;
            st_d.slots[st_q.tail].dst  = alloc_dst;
            st_d.tail = step_idx(st_q.tail);
        end
        if (do_retire) begin
            st_d.slots[st_q.head].used = 1'b0;
            st_d.head = step_idx(st_q.head);
        end
        st_d.count = st_q.count + CNT_W'(do_alloc) - CNT_W'(do_retire);
        if (flush) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: occupancy never exceeds capacity
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));
    // R3: a full queue refuses allocation
    a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == CNT_W'(DEPTH)) |-> !alloc_ready);
    // R7: a flush leaves nothing behind
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.count == '0 && !commit_valid && alloc_tag == '0));
    // R5: register writes only at retirement
    a_r5_we_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> commit_valid);
    // R4: a normal retirement moves the head by exactly one slot
    a_r4_head_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !flush) |=>
        (st_q.head == (($past(st_q.head) == TAG_W'(DEPTH - 1)) ? '0 : $past(st_q.head) + TAG_W'(1))));
    // R9: an empty queue never retires
    a_r9_empty_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == '0) |-> !commit_valid);
endmodule

// File: tb/tb_rob_core.sv
module tb_rob_core;
    localparam int D  = 8;
    localparam int XL = 16;
    localparam int AW = 4;
    localparam int TW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic          alloc_valid = 0;
    logic [1:0]    alloc_kind = 0;
    logic [XL-1:0] alloc_pc = 0;
    logic [AW-1:0] alloc_dst = 0;
    logic [XL-1:0] alloc_pred = 0;
    logic          alloc_ready;
    logic [TW-1:0] alloc_tag;
    logic          res_valid = 0;
    logic [TW-1:0] res_tag = 0;
    logic [XL-1:0] res_value = 0;
    logic          res_zero = 0;
    logic          mem_go_valid = 0;
    logic [TW-1:0] mem_go_tag = 0;
    logic          commit_valid, rf_we, flush;
    logic [AW-1:0] rf_waddr;
    logic [XL-1:0] rf_wdata, redirect_pc;

    always #2.5 clk = ~clk;

    rob_core #(.DEPTH(D), .XLEN(XL), .AREG_W(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_pc(alloc_pc),
        .alloc_dst(alloc_dst), .alloc_pred(alloc_pred), .alloc_ready(alloc_ready),
        .alloc_tag(alloc_tag), .res_valid(res_valid), .res_tag(res_tag),
        .res_value(res_value), .res_zero(res_zero), .mem_go_valid(mem_go_valid),
        .mem_go_tag(mem_go_tag), .commit_valid(commit_valid), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .flush(flush), .redirect_pc(redirect_pc)
    );

    int total = 0, bad = 0;
    bit finished = 0;
    int flushes = 0;

    // reference model
    bit          m_used[D], m_done[D], m_sent[D], m_zero[D];
    logic [1:0]  m_kind[D];
    logic [XL-1:0] m_pc[D], m_pred[D], m_val[D];
    logic [AW-1:0] m_dst[D];
    int m_head = 0, m_tail = 0, m_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit is_mem(input logic [1:0] k);
        return k == 2'd2 || k == 2'd3;
    endfunction

    function automatic logic [XL-1:0] exp_next(input int h);
        return m_zero[h] ? m_val[h] : m_pc[h] + XL'(1);
    endfunction

    // check outputs against model, then advance model and DUT one cycle
    task automatic step();
        bit hv, fl, we, rdy;
        logic [XL-1:0] nx;
        hv  = m_used[m_head] && m_done[m_head];
        nx  = exp_next(m_head);
        fl  = hv && m_kind[m_head] == 2'd1 && m_pred[m_head] != nx;
        we  = hv && (m_kind[m_head] == 2'd0 || m_kind[m_head] == 2'd2);
        rdy = (m_cnt < D) && !fl;
        chk(alloc_ready == rdy, "R3", "alloc_ready", alloc_ready, rdy);
        chk(alloc_tag == TW'(m_tail), "R2", "alloc_tag", alloc_tag, m_tail);
        chk(commit_valid == hv, "R4 R8 R9", "commit_valid", commit_valid, hv);
        chk(rf_we == we, "R5", "rf_we", rf_we, we);
        if (we) begin
            chk(rf_waddr == m_dst[m_head], "R5", "rf_waddr", rf_waddr, m_dst[m_head]);
            chk(rf_wdata == m_val[m_head], "R5", "rf_wdata", rf_wdata, m_val[m_head]);
        end
        chk(flush == fl, "R6 R7", "flush", flush, fl);
        if (fl) begin
            flushes++;
            chk(redirect_pc == nx, "R7", "redirect_pc", redirect_pc, nx);
        end
        for (int i = 0; i < D; i++) begin
            if (res_valid && res_tag == TW'(i) && m_used[i] && (!is_mem(m_kind[i]) || m_sent[i])) begin
                m_done[i] = 1; m_val[i] = res_value; m_zero[i] = res_zero;
            end
            if (mem_go_valid && mem_go_tag == TW'(i) && m_used[i] && is_mem(m_kind[i])) m_sent[i] = 1;
        end
        if (alloc_valid && rdy) begin
            m_used[m_tail] = 1; m_done[m_tail] = 0; m_sent[m_tail] = 0; m_zero[m_tail] = 0;
            m_kind[m_tail] = alloc_kind; m_pc[m_tail] = alloc_pc; m_pred[m_tail] = alloc_pred;
            m_dst[m_tail] = alloc_dst; m_val[m_tail] = '0;
            m_tail = (m_tail + 1) % D; m_cnt++;
        end
        if (hv) begin
            if (fl) begin
                for (int i = 0; i < D; i++) m_used[i] = 0;
                m_head = 0; m_tail = 0; m_cnt = 0;
            end else begin
                m_used[m_head] = 0; m_head = (m_head + 1) % D; m_cnt--;
            end
        end
        @(posedge clk);
        @(negedge clk);
        alloc_valid = 0; res_valid = 0; mem_go_valid = 0;
    endtask

    task automatic put(input logic [1:0] k, input int pc, input int dst, input int pred);
        alloc_valid = 1; alloc_kind = k; alloc_pc = XL'(pc); alloc_dst = AW'(dst); alloc_pred = XL'(pred);
    endtask

    task automatic res(input int t, input int v, input bit z);
        res_valid = 1; res_tag = TW'(t); res_value = XL'(v); res_zero = z;
    endtask

    task automatic drain();
        for (int n = 0; n < 4 * D && m_cnt > 0; n++) begin
            for (int i = 0; i < D; i++) begin
                if (m_used[i] && !m_done[i]) begin
                    if (is_mem(m_kind[i]) && !m_sent[i]) begin
                        mem_go_valid = 1; mem_go_tag = TW'(i);
                    end else begin
                        res(i, m_kind[i] == 2'd1 ? 0 : 7, 0);
                    end
                    break;
                end
            end
            step();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < D; i++) begin
            m_used[i] = 0; m_done[i] = 0; m_sent[i] = 0; m_zero[i] = 0;
            m_kind[i] = 0; m_pc[i] = 0; m_pred[i] = 0; m_val[i] = 0; m_dst[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(alloc_ready == 1, "R1", "alloc_ready", alloc_ready, 1);
        chk(alloc_tag == 0, "R1", "alloc_tag", alloc_tag, 0);
        chk(commit_valid == 0 && rf_we == 0 && flush == 0, "R1", "commit/we/flush", commit_valid, 0);

        // R3: fill, then one refused offer
        for (int i = 0; i < D + 1; i++) begin put(2'd0, 100 + i, i, 0); step(); end
        chk(alloc_ready == 0, "R3", "full ready", alloc_ready, 0);
        // R4: complete youngest first
        for (int i = D - 1; i >= 0; i--) begin res(i, 200 + i, 0); step(); end
        drain();

        // R6: correct predictions, both condition values
        put(2'd1, 20, 0, 21); step(); res(m_tail == 0 ? D - 1 : m_tail - 1, 500, 0); step();
        put(2'd1, 30, 0, 50); step(); res(m_tail == 0 ? D - 1 : m_tail - 1, 50, 1); step();
        drain();
        // R7: taken target differs from guess
        put(2'd1, 40, 0, 41); step(); put(2'd0, 41, 1, 0); step(); put(2'd0, 42, 2, 0); step();
        res(m_tail >= 3 ? m_tail - 3 : m_tail + D - 3, 99, 1); step();
        step(); step();
        chk(alloc_tag == 0, "R7", "tag after flush", alloc_tag, 0);
        // R7: guessed taken but fell through
        put(2'd1, 60, 0, 70); step(); res(0, 70, 0); step(); step();

        // R8: load result before dispatch ignored, then accepted
        put(2'd2, 80, 5, 0); step();
        res(0, 33, 0); step(); step();
        res(0, 34, 0); mem_go_valid = 1; mem_go_tag = 0; step(); step();
        res(0, 35, 0); step(); step();
        // R9: stale tag
        res(3, 1, 1); mem_go_valid = 1; mem_go_tag = 4; step(); step();

        // random phase
        begin
            int seed_dummy;
            seed_dummy = $urandom(12345);
        end
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(99) < 55) begin
                logic [1:0] k;
                int pc;
                k = 2'($urandom_range(3));
                pc = $urandom_range(1000);
                put(k, pc, $urandom_range(15), $urandom_range(1) ? pc + 1 : $urandom_range(1000));
            end
            if ($urandom_range(99) < 50) begin
                int t;
                t = $urandom_range(D - 1);
                res(t, $urandom_range(1) ? int'(m_pred[t]) : $urandom_range(1000), bit'($urandom_range(1)));
            end
            if ($urandom_range(99) < 40) begin
                mem_go_valid = 1; mem_go_tag = TW'($urandom_range(D - 1));
            end
            step();
        end
        chk(flushes > 2, "R7", "flush events seen", flushes, 3);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule